// File: doc/BRIEF.md
# Bit-Reversed Address Generation Unit

This block is the pointer-update stage of a DSP-style address generator. It keeps a small bank of address pointers. Each pointer has its own offset register and its own modifier register. On an access request the selected pointer is presented at once as the effective address. On the following clock edge the pointer is replaced by its updated value. The update adds +1, -1, a sign-extended displacement, or the pointer's offset register.

The modifier register of a pointer selects the arithmetic. Linear arithmetic is plain two's-complement addition with wrap-around. Reverse-carry arithmetic passes the carry from the most significant bit toward bit 0. When the offset is half the transform length, stepping by the offset walks a buffer in bit-reversed order for FFT data access. The buffer base must be aligned to the transform length, and the bits above the transform field then never change.

The registers are loaded through a single write port that selects the pointer, offset or modifier bank. The memory, modulo arithmetic and instruction decoding sit outside this block.

Top module: `addr_ptr_unit`

## Requirements
- R1: After reset every pointer and every offset register holds 0, and every modifier holds 16'hFFFF, which selects linear arithmetic.
- R2: `ea_out` equals the current value of pointer `upd_idx` in the same cycle, without a register stage. When `upd_en` is high, the updated pointer becomes visible after the next rising clock edge.
- R3: In linear arithmetic, `upd_mode` 0 adds 1 and `upd_mode` 1 subtracts 1, both modulo 65,536. So 16'hFFFF+1 gives 0, and 0-1 gives 16'hFFFF.
- R4: In linear arithmetic, `upd_mode` 2 adds `upd_disp` sign-extended from DISP_W bits. For example, 8'hF0 subtracts 16.
- R5: In linear arithmetic, `upd_mode` 3 adds the pointer's offset register modulo 65,536. An offset of 16'hFFF0 therefore acts as -16, and 16'h8000 adds 32,768.
- R6: A modifier value of 16'h0000 selects reverse-carry arithmetic. Every other modifier value, such as 16'h1234, selects linear arithmetic.
- R7: In reverse-carry arithmetic with offset 512 and a start value of 0, repeated `upd_mode` 3 steps produce 0, 512, 256, 768, 128, 640, 384, 896.
- R8: In reverse-carry arithmetic with offset 2^(K-1) and a base aligned to 2^K, each `upd_mode` 3 step equals three operations on the low K bits: reverse them, add 1, and reverse them again. The bits above K are left unchanged, so after 2^K steps the pointer is back at the base.
- R9: In reverse-carry arithmetic, `upd_mode` 0, 1 and 2 apply the same downward-carry sum with the amount 16'h0001, 16'hFFFF or the sign-extended displacement. For example, 1 plus 1 gives 0, 0 minus 1 gives 16'hFFFF, and 2 plus a displacement of 4 gives 6. An offset of 0 leaves the pointer unchanged.
- R10: When `wr_en` is high, `wr_sel` chooses the bank: 0 for pointers, 1 for offsets, 2 for modifiers. The value `wr_data` is written to entry `wr_idx` of that bank. A `wr_sel` of 3 writes nothing.
- R11: A pointer write and an update aimed at the same pointer in the same cycle leave the written value. An update aimed at a different pointer in the same cycle still takes place.
- R12: An update changes only the selected pointer. Offset and modifier registers change only through the write port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Bank select: 0 pointer, 1 offset, 2 modifier, 3 none |
| wr_idx | input | IDX_W | Entry written |
| wr_data | input | ADDR_W | Write value |
| upd_en | input | 1 | Access request; post-update the selected pointer |
| upd_idx | input | IDX_W | Pointer selected for access |
| upd_mode | input | 2 | Step: 0 +1, 1 -1, 2 +displacement, 3 +offset |
| upd_disp | input | DISP_W | Signed displacement for step 2 |
| ea_out | output | ADDR_W | Effective address (pre-update pointer value) |

## Verification
The effective address is due in the same cycle as the request, so the bench reads `ea_out` 1 ns after it drives the index on a falling edge, before the next rising edge. The updated pointer, and any register write, is due one rising edge later. The bench reads it back through `ea_out` with `upd_en` low, sampling 1 ns after that edge. The bench sequences are checked one step at a time against a bit-reversal model computed inside the bench, and the first value is always the pre-update address.

// File: rtl/addr_ptr_pkg.sv
package addr_ptr_pkg;

   typedef enum logic [1:0] {
      STEP_INC  = 2'd0,
      STEP_DEC  = 2'd1,
      STEP_DISP = 2'd2,
      STEP_OFS  = 2'd3
   } step_e;

   typedef enum logic [1:0] {
      BANK_PTR  = 2'd0,
      BANK_OFS  = 2'd1,
      BANK_MOD  = 2'd2,
      BANK_NONE = 2'd3
   } bank_e;

endpackage

// File: rtl/rc_adder.sv
module rc_adder #(
   parameter int W    = 16,
   parameter int IMPL = 0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] s
);

   if (W < 2) begin : g_bad_w
      $error("rc_adder: W must be at least 2");
   end

   if (IMPL == 0) begin : g_mirror
      logic [W-1:0] a_rev, b_rev, sum_rev;
      for (genvar i = 0; i < W; i++) begin : g_rev
         assign a_rev[i] = a[W-1-i];
         assign b_rev[i] = b[W-1-i];
         assign s[i]     = sum_rev[W-1-i];
      end
      assign sum_rev = a_rev + b_rev;
   end else begin : g_ripple
      logic [W-1:0] cin;
      assign cin[W-1] = 1'b0;
      for (genvar i = W-1; i >= 0; i--) begin : g_bit
         assign s[i] = a[i] ^ b[i] ^ cin[i];
         if (i > 0) begin : g_carry
            assign cin[i-1] = (a[i] & b[i]) | (cin[i] & (a[i] ^ b[i]));
         end
      end
   end

endmodule

// File: rtl/ptr_step_calc.sv
module ptr_step_calc
   import addr_ptr_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DISP_W  = 8,
   parameter bit RC_EN   = 1'b1,
   parameter int RC_IMPL = 0
) (
   input  logic [ADDR_W-1:0] r_cur,
   input  logic [ADDR_W-1:0] n_cur,
   input  logic [ADDR_W-1:0] m_cur,
   input  step_e             mode,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] r_nxt
);

   if (DISP_W < 1 || DISP_W > ADDR_W) begin : g_bad_disp
      $error("ptr_step_calc: DISP_W must lie in 1..ADDR_W");
   end

   logic [ADDR_W-1:0] amount;
   logic [ADDR_W-1:0] lin_sum;

   always_comb begin
      unique case (mode)
         STEP_INC:  amount = ADDR_W'(1);
         STEP_DEC:  amount = '1;
         STEP_DISP: amount = ADDR_W'($signed(disp));
         default:   amount = n_cur;
      endcase
   end

   assign lin_sum = r_cur + amount;

   if (RC_EN) begin : g_rc
      logic [ADDR_W-1:0] rc_sum;
      logic              use_rc;

      rc_adder #(.W(ADDR_W), .IMPL(RC_IMPL)) u_rc (
         .a (r_cur),
         .b (amount),
         .s (rc_sum)
      );

      assign use_rc = (m_cur == '0);
      assign r_nxt  = use_rc ? rc_sum : lin_sum;
   end else begin : g_lin
      logic m_unused;
      assign m_unused = ^m_cur;
      assign r_nxt    = lin_sum;
   end

endmodule

// File: rtl/ptr_bank.sv
module ptr_bank
   import addr_ptr_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int NUM_PTR = 4,
   parameter int IDX_W   = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  bank_e                          wr_bank,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic [ADDR_W-1:0]              wr_data,
   input  logic                           upd_en,
   input  logic [IDX_W-1:0]               upd_idx,
   input  logic [ADDR_W-1:0]              upd_val,
   output logic [NUM_PTR-1:0][ADDR_W-1:0] r_q,
   output logic [NUM_PTR-1:0][ADDR_W-1:0] n_q,
   output logic [NUM_PTR-1:0][ADDR_W-1:0] m_q
);

   if ((1 << IDX_W) < NUM_PTR) begin : g_bad_idx
      $error("ptr_bank: IDX_W too narrow for NUM_PTR");
   end

   for (genvar g = 0; g < NUM_PTR; g++) begin : g_set
      logic hit_w, hit_u;
      assign hit_w = wr_en  && (wr_idx  == IDX_W'(g));
      assign hit_u = upd_en && (upd_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r_q[g] <= '0;
         end else if (hit_w && wr_bank == BANK_PTR) begin
            r_q[g] <= wr_data;
         end else if (hit_u) begin
            r_q[g] <= upd_val;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            n_q[g] <= '0;
         end else if (hit_w && wr_bank == BANK_OFS) begin
            n_q[g] <= wr_data;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            m_q[g] <= '1;
         end else if (hit_w && wr_bank == BANK_MOD) begin
            m_q[g] <= wr_data;
         end
      end
   end

endmodule

// File: rtl/addr_ptr_unit.sv
module addr_ptr_unit
   import addr_ptr_pkg::*;
#(
   parameter int  ADDR_W  = 16,
   parameter int  NUM_PTR = 4,
   parameter int  DISP_W  = 8,
   parameter bit  RC_EN   = 1'b1,
   parameter int  RC_IMPL = 0,
   localparam int IDX_W   = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              upd_en,
   input  logic [IDX_W-1:0]  upd_idx,
   input  logic [1:0]        upd_mode,
   input  logic [DISP_W-1:0] upd_disp,
   output logic [ADDR_W-1:0] ea_out
);

   if (NUM_PTR < 2) begin : g_bad_num
      $error("addr_ptr_unit: NUM_PTR must be at least 2");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("addr_ptr_unit: ADDR_W must be at least 2");
   end

   logic [NUM_PTR-1:0][ADDR_W-1:0] r_q, n_q, m_q;
   logic [ADDR_W-1:0]              r_cur, n_cur, m_cur, r_nxt;

   assign r_cur  = r_q[upd_idx];
   assign n_cur  = n_q[upd_idx];
   assign m_cur  = m_q[upd_idx];
   assign ea_out = r_cur;

   ptr_step_calc #(
      .ADDR_W  (ADDR_W),
      .DISP_W  (DISP_W),
      .RC_EN   (RC_EN),
      .RC_IMPL (RC_IMPL)
   ) u_calc (
      .r_cur (r_cur),
      .n_cur (n_cur),
      .m_cur (m_cur),
      .mode  (step_e'(upd_mode)),
      .disp  (upd_disp),
      .r_nxt (r_nxt)
   );

   ptr_bank #(
      .ADDR_W  (ADDR_W),
      .NUM_PTR (NUM_PTR),
      .IDX_W   (IDX_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_bank (bank_e'(wr_sel)),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .upd_en  (upd_en),
      .upd_idx (upd_idx),
      .upd_val (r_nxt),
      .r_q     (r_q),
      .n_q     (n_q),
      .m_q     (m_q)
   );

endmodule

// File: rtl/addr_ptr_chk.sv
module addr_ptr_chk #(
   parameter int ADDR_W  = 16,
   parameter int NUM_PTR = 4,
   parameter int IDX_W   = 2
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           wr_en,
   input logic [1:0]                     wr_sel,
   input logic [IDX_W-1:0]               wr_idx,
   input logic [ADDR_W-1:0]              wr_data,
   input logic                           upd_en,
   input logic [IDX_W-1:0]               upd_idx,
   input logic [1:0]                     upd_mode,
   input logic [ADDR_W-1:0]              ea_out,
   input logic [NUM_PTR-1:0][ADDR_W-1:0] r_q,
   input logic [NUM_PTR-1:0][ADDR_W-1:0] n_q,
   input logic [NUM_PTR-1:0][ADDR_W-1:0] m_q
);

   // R10
   ptr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0) |=> r_q[$past(wr_idx)] == $past(wr_data));

   // R3
   lin_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !wr_en && upd_mode == 2'd0 && m_q[upd_idx] != '0)
      |=> r_q[$past(upd_idx)] == ADDR_W'($past(ea_out) + ADDR_W'(1)));

   // R3
   lin_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !wr_en && upd_mode == 2'd1 && m_q[upd_idx] != '0)
      |=> r_q[$past(upd_idx)] == ADDR_W'($past(ea_out) - ADDR_W'(1)));

   // R9
   rc_zero_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !wr_en && upd_mode == 2'd3 && m_q[upd_idx] == '0 && n_q[upd_idx] == '0)
      |=> r_q[$past(upd_idx)] == $past(ea_out));

   // R12
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_en && !wr_en) |=> $stable(r_q));

   // R12
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(n_q) && $stable(m_q)));

endmodule

bind addr_ptr_unit addr_ptr_chk #(
   .ADDR_W  (ADDR_W),
   .NUM_PTR (NUM_PTR),
   .IDX_W   (IDX_W)
) u_addr_ptr_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .wr_idx   (wr_idx),
   .wr_data  (wr_data),
   .upd_en   (upd_en),
   .upd_idx  (upd_idx),
   .upd_mode (upd_mode),
   .ea_out   (ea_out),
   .r_q      (r_q),
   .n_q      (n_q),
   .m_q      (m_q)
);

// File: tb/test_addr_ptr_unit.sv
module test_addr_ptr_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [1:0]  wr_idx = 2'd0;
   logic [15:0] wr_data = 16'h0;
   logic        upd_en = 1'b0;
   logic [1:0]  upd_idx = 2'd0;
   logic [1:0]  upd_mode = 2'd0;
   logic [7:0]  upd_disp = 8'h0;
   logic [15:0] ea_out;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   addr_ptr_unit i_addr_ptr_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .upd_en   (upd_en),
      .upd_idx  (upd_idx),
      .upd_mode (upd_mode),
      .upd_disp (upd_disp),
      .ea_out   (ea_out)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one clock cycle with optional write and optional update; returns pre-update ea
   task automatic cyc(input logic we, input logic [1:0] sel, input logic [1:0] widx,
                      input logic [15:0] wdat, input logic ue, input logic [1:0] uidx,
                      input logic [1:0] mode, input logic [7:0] disp,
                      output logic [15:0] ea_pre);
      @(negedge clk);
      wr_en = we; wr_sel = sel; wr_idx = widx; wr_data = wdat;
      upd_en = ue; upd_idx = uidx; upd_mode = mode; upd_disp = disp;
      #1 ea_pre = ea_out;
      @(posedge clk);
      #1;
      wr_en = 1'b0; upd_en = 1'b0;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [1:0] idx, input logic [15:0] d);
      logic [15:0] unused_ea;
      cyc(1'b1, sel, idx, d, 1'b0, 2'd0, 2'd0, 8'h0, unused_ea);
   endtask

   task automatic step(input logic [1:0] idx, input logic [1:0] mode, input logic [7:0] disp,
                       output logic [15:0] ea_pre);
      cyc(1'b0, 2'd0, 2'd0, 16'h0, 1'b1, idx, mode, disp, ea_pre);
   endtask

   task automatic peek(input logic [1:0] idx, output logic [15:0] v);
      upd_en = 1'b0;
      upd_idx = idx;
      #1 v = ea_out;
   endtask

   function automatic logic [15:0] rc_model_k(input logic [15:0] r, input int k);
      logic [15:0] mask, lo, rv, back;
      mask = (16'h1 << k) - 16'h1;
      lo = r & mask;
      rv = '0;
      for (int i = 0; i < k; i++) rv[k-1-i] = lo[i];
      rv = (rv + 16'h1) & mask;
      back = '0;
      for (int i = 0; i < k; i++) back[k-1-i] = rv[i];
      return (r & ~mask) | back;
   endfunction

   task automatic t_reset();
      logic [15:0] v;
      for (int i = 0; i < 4; i++) begin
         peek(2'(i), v);
         chk("R1 pointer reset", v, 16'h0);
      end
      step(2'd3, 2'd0, 8'h0, v);
      step(2'd3, 2'd0, 8'h0, v);
      peek(2'd3, v);
      chk("R1 modifier reset linear", v, 16'h0002);
      step(2'd2, 2'd3, 8'h0, v);
      peek(2'd2, v);
      chk("R1 offset reset zero", v, 16'h0);
   endtask

   task automatic t_linear();
      logic [15:0] v;
      wr(2'd0, 2'd0, 16'hFFFE);
      step(2'd0, 2'd0, 8'h0, v);
      chk("R2 ea is pre-update pointer", v, 16'hFFFE);
      peek(2'd0, v);
      chk("R3 inc", v, 16'hFFFF);
      step(2'd0, 2'd0, 8'h0, v);
      peek(2'd0, v);
      chk("R3 inc wrap", v, 16'h0000);
      step(2'd0, 2'd1, 8'h0, v);
      peek(2'd0, v);
      chk("R3 dec wrap", v, 16'hFFFF);
      wr(2'd0, 2'd1, 16'h0100);
      step(2'd1, 2'd2, 8'hF0, v);
      peek(2'd1, v);
      chk("R4 negative disp", v, 16'h00F0);
      step(2'd1, 2'd2, 8'h7F, v);
      peek(2'd1, v);
      chk("R4 positive disp", v, 16'h016F);
      wr(2'd1, 2'd1, 16'hFFF0);
      step(2'd1, 2'd3, 8'h0, v);
      peek(2'd1, v);
      chk("R5 offset as -16", v, 16'h015F);
      wr(2'd1, 2'd1, 16'h8000);
      step(2'd1, 2'd3, 8'h0, v);
      peek(2'd1, v);
      chk("R5 offset 32768", v, 16'h815F);
   endtask

   task automatic t_modenc();
      logic [15:0] v;
      wr(2'd2, 2'd2, 16'h1234);
      wr(2'd0, 2'd2, 16'h0000);
      step(2'd2, 2'd0, 8'h0, v);
      step(2'd2, 2'd0, 8'h0, v);
      peek(2'd2, v);
      chk("R6 other modifier is linear", v, 16'h0002);
      wr(2'd2, 2'd2, 16'h0000);
      wr(2'd0, 2'd2, 16'h0000);
      step(2'd2, 2'd0, 8'h0, v);
      peek(2'd2, v);
      chk("R6 zero modifier reverse carry step1", v, 16'h0001);
      step(2'd2, 2'd0, 8'h0, v);
      peek(2'd2, v);
      chk("R6 zero modifier reverse carry step2", v, 16'h0000);
   endtask

   task automatic t_rc_fft();
      logic [15:0] v;
      logic [15:0] exp_seq [8] = '{16'd0, 16'd512, 16'd256, 16'd768,
                                   16'd128, 16'd640, 16'd384, 16'd896};
      wr(2'd2, 2'd0, 16'h0000);
      wr(2'd1, 2'd0, 16'd512);
      wr(2'd0, 2'd0, 16'h0000);
      for (int i = 0; i < 8; i++) begin
         step(2'd0, 2'd3, 8'h0, v);
         chk("R7 fft order", v, exp_seq[i]);
      end
   endtask

   task automatic t_rc_base(input logic [15:0] base, input int k);
      logic [15:0] v, model;
      wr(2'd2, 2'd0, 16'h0000);
      wr(2'd1, 2'd0, 16'h1 << (k-1));
      wr(2'd0, 2'd0, base);
      model = base;
      for (int i = 0; i < (1 << k); i++) begin
         step(2'd0, 2'd3, 8'h0, v);
         model = rc_model_k(model, k);
         peek(2'd0, v);
         chk("R8 reverse-increment-reverse", v, model);
      end
      chk("R8 back at base", v, base);
   endtask

   task automatic t_rc_other();
      logic [15:0] v;
      wr(2'd2, 2'd3, 16'h0000);
      wr(2'd0, 2'd3, 16'h0001);
      step(2'd3, 2'd0, 8'h0, v);
      peek(2'd3, v);
      chk("R9 rc plus one", v, 16'h0000);
      step(2'd3, 2'd1, 8'h0, v);
      peek(2'd3, v);
      chk("R9 rc minus one", v, 16'hFFFF);
      wr(2'd0, 2'd3, 16'h0002);
      step(2'd3, 2'd2, 8'h04, v);
      peek(2'd3, v);
      chk("R9 rc displacement", v, 16'h0006);
      wr(2'd1, 2'd3, 16'h0000);
      step(2'd3, 2'd3, 8'h0, v);
      peek(2'd3, v);
      chk("R9 rc zero offset", v, 16'h0006);
   endtask

   task automatic t_write_prio();
      logic [15:0] v;
      wr(2'd2, 2'd1, 16'hFFFF);
      wr(2'd0, 2'd0, 16'h0AAA);
      wr(2'd0, 2'd3, 16'h0BBB);
      cyc(1'b1, 2'd0, 2'd1, 16'h4444, 1'b1, 2'd1, 2'd0, 8'h0, v);
      peek(2'd1, v);
      chk("R11 write wins over update", v, 16'h4444);
      cyc(1'b1, 2'd0, 2'd2, 16'h0010, 1'b1, 2'd1, 2'd0, 8'h0, v);
      peek(2'd1, v);
      chk("R11 update on other pointer", v, 16'h4445);
      peek(2'd2, v);
      chk("R10 pointer write", v, 16'h0010);
      peek(2'd0, v);
      chk("R12 unselected pointer 0 kept", v, 16'h0AAA);
      peek(2'd3, v);
      chk("R12 unselected pointer 3 kept", v, 16'h0BBB);
   endtask

   task automatic t_ignore_sel();
      logic [15:0] v;
      wr(2'd1, 2'd0, 16'h0003);
      wr(2'd2, 2'd0, 16'hFFFF);
      wr(2'd0, 2'd0, 16'h0100);
      wr(2'd3, 2'd0, 16'hDEAD);
      peek(2'd0, v);
      chk("R10 sel 3 leaves pointer", v, 16'h0100);
      step(2'd0, 2'd3, 8'h0, v);
      peek(2'd0, v);
      chk("R10 sel 3 leaves offset", v, 16'h0103);
      step(2'd0, 2'd0, 8'h0, v);
      step(2'd0, 2'd0, 8'h0, v);
      peek(2'd0, v);
      chk("R10 sel 3 leaves modifier linear", v, 16'h0105);
   endtask

   initial begin : watchdog
      #2000000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_linear();
      t_modenc();
      t_rc_fft();
      t_rc_base(16'h0C00, 10);
      t_rc_base(16'h5670, 4);
      t_rc_other();
      t_write_prio();
      t_ignore_sel();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule